// File: doc/BRIEF.md
# Trap Vector and Return Unit

This unit chooses where the core fetches from next when it takes an exception or returns from a handler. When the take strobe is high, the unit looks up a fixed vector offset for the incoming event code and adds it to the programmable handler base. It also decides what goes into the saved exception address register, and whether the core must switch to its shadow register set. When the return strobe is high, it jumps back to the saved exception address. If that address has bit 0 clear, the core is going back to normal mode, so the unit asks to leave shadow state and asks for pending interrupts to be checked again.

Bit 0 of a program counter marks privileged (handler) mode. Every vector offset is odd, so each handler address is privileged. All outputs come from registers and change on the rising clock edge after the strobe. Reset is synchronous and active low. While reset is held, the PC follows the handler base plus the reset offset.

Top module: `trap_return_unit`

## Requirements
- R1: While rst_n is low, and on the first edge after it rises, pc_out equals handler_base + 0x0001, npc_out equals pc_out + 4, and every pulse output is low.
- R2: The event code selects a vector offset. The codes are: 1 reset 0x0001, 2 machine check 0x0401, 4 interrupt 0x0101, 5 normal data-TLB miss 0x0201, 6 privileged data-TLB miss 0x0281, 7 alignment 0x0301, 8 data-TLB fault 0x0381, 9 data access violation 0x0381, 10 instruction-TLB miss 0x0181, 11 instruction-TLB fault 0x0181, 12 instruction access violation 0x0081, 13 unimplemented opcode 0x0481, 14 floating point disabled 0x0581, 15 handler call 0x2001, 16 integer overflow 0x0501.
- R3: On the edge that samples take_exc with a supported code, pc_out becomes handler_base + offset and npc_out becomes pc_out + 4. redirect pulses high for that one cycle.
- R4: A supported event writes cur_pc to the saved address: epc_we is high and epc_out equals cur_pc. Exceptions to this rule are given in R5 and R6.
- R5: An interrupt (code 4) taken while cur_pc bit 0 is set does not write the saved address (epc_we stays low).
- R6: A handler call (code 15) writes cur_pc + 4 to the saved address.
- R7: shadow_enter pulses when an exception is taken with cur_pc bit 0 clear. It stays low when bit 0 is set.
- R8: A return with cur_pc bit 0 clear pulses illegal_fault and vectors to handler_base + 0x0481. It also saves cur_pc and pulses shadow_enter.
- R9: A return with cur_pc bit 0 set loads pc_out with epc_in and npc_out with epc_in + 4, and pulses redirect.
- R10: On a privileged return, shadow_leave and recheck_irq both pulse when epc_in bit 0 is clear. Both stay low when it is set.
- R11: Code 0, code 3 (arithmetic) and codes above 16 pulse unsupported. They leave pc_out and npc_out unchanged and do not write the saved address.
- R12: When take_exc and ret_exc are high together, the exception is taken and the return is ignored.
- R13: With no strobe, pc_out and npc_out hold their values and every pulse output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cur_pc | input | PC_W | PC of the instruction taking the event; bit 0 marks privileged mode |
| fault_code | input | 5 | Event code, see R2 |
| take_exc | input | 1 | Take the event named by fault_code |
| ret_exc | input | 1 | Execute a return from handler |
| handler_base | input | PC_W | Handler base register |
| epc_in | input | PC_W | Current saved exception address |
| pc_out | output | PC_W | New PC |
| npc_out | output | PC_W | Next PC (pc_out + 4) |
| epc_out | output | PC_W | Value to write to the saved exception address |
| epc_we | output | 1 | Write enable for epc_out |
| shadow_enter | output | 1 | Request to switch to shadow registers |
| shadow_leave | output | 1 | Request to leave shadow registers |
| illegal_fault | output | 1 | Return attempted outside privileged mode |
| recheck_irq | output | 1 | Re-evaluate pending interrupts |
| unsupported | output | 1 | Event code has no vector |
| redirect | output | 1 | pc_out/npc_out were just loaded |

## Verification
A wrong offset entry or a misdecoded code shows up at pc_out one edge after the strobe, at the same time as a redirect pulse. Errors in the mode decision affect epc_we and shadow_enter at that same edge. The interrupt-from-handler and handler-call paths are the likely slips, because each differs from the general rule by a single condition. A return-path error shows up as a wrong pc_out or as a leave/recheck pulse that does not match epc_in bit 0. A broken hold path lets pc_out drift on an idle cycle and is seen on the very next edge.

// File: rtl/trv_pkg.sv
package trv_pkg;

    typedef enum logic [4:0] {
        EV_NONE       = 5'd0,
        EV_RESET      = 5'd1,
        EV_MCHK       = 5'd2,
        EV_ARITH      = 5'd3,
        EV_INTR       = 5'd4,
        EV_DMISS      = 5'd5,
        EV_DMISS_PRIV = 5'd6,
        EV_ALIGN      = 5'd7,
        EV_DFAULT     = 5'd8,
        EV_DACV       = 5'd9,
        EV_IMISS      = 5'd10,
        EV_IFAULT     = 5'd11,
        EV_IACV       = 5'd12,
        EV_OPDEC      = 5'd13,
        EV_FPOFF      = 5'd14,
        EV_CALL       = 5'd15,
        EV_IOVF       = 5'd16
    } ev_e;

    localparam int          OFF_W     = 14;
    localparam int          STEP      = 4;
    localparam logic [13:0] OFF_RESET = 14'h0001;
    localparam logic [13:0] OFF_OPDEC = 14'h0481;

    // Returns {supported, offset}
    function automatic logic [OFF_W:0] vec_lookup(input logic [4:0] code);
        logic [OFF_W:0] r;
        case (code)
            EV_RESET:             r = {1'b1, 14'h0001};
            EV_MCHK:              r = {1'b1, 14'h0401};
            EV_INTR:              r = {1'b1, 14'h0101};
            EV_DMISS:             r = {1'b1, 14'h0201};
            EV_DMISS_PRIV:        r = {1'b1, 14'h0281};
            EV_ALIGN:             r = {1'b1, 14'h0301};
            EV_DFAULT, EV_DACV:   r = {1'b1, 14'h0381};
            EV_IMISS, EV_IFAULT:  r = {1'b1, 14'h0181};
            EV_IACV:              r = {1'b1, 14'h0081};
            EV_OPDEC:             r = {1'b1, 14'h0481};
            EV_FPOFF:             r = {1'b1, 14'h0581};
            EV_CALL:              r = {1'b1, 14'h2001};
            EV_IOVF:              r = {1'b1, 14'h0501};
            default:              r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/trv_vector_lookup.sv
module trv_vector_lookup
    import trv_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic [4:0]      code,
    input  logic [PC_W-1:0] base,
    output logic [PC_W-1:0] target,
    output logic            hit
);
    logic [OFF_W:0] entry;

    always_comb begin
        entry  = vec_lookup(code);
        hit    = entry[OFF_W];
        target = base + PC_W'(entry[OFF_W-1:0]);
    end
endmodule

// File: rtl/trv_epc_calc.sv
module trv_epc_calc
    import trv_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic [4:0]      code,
    input  logic [PC_W-1:0] cur_pc,
    output logic            save_en,
    output logic [PC_W-1:0] save_val
);
    logic priv;
    logic is_call;

    always_comb begin
        priv     = cur_pc[0];
        is_call  = (code == EV_CALL);
        // an interrupt arriving inside a handler keeps the older restart point
        save_en  = !((code == EV_INTR) && priv);
        save_val = is_call ? (cur_pc + PC_W'(STEP)) : cur_pc;
    end
endmodule

// File: rtl/trv_return_ctl.sv
module trv_return_ctl
    import trv_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic [PC_W-1:0] cur_pc,
    input  logic [PC_W-1:0] epc_in,
    input  logic [PC_W-1:0] base,
    output logic            illegal,
    output logic [PC_W-1:0] target,
    output logic            leave
);
    always_comb begin
        illegal = !cur_pc[0];
        target  = illegal ? (base + PC_W'(OFF_OPDEC)) : epc_in;
        leave   = !illegal && !epc_in[0];
    end
endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
    import trv_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] cur_pc,
    input  logic [4:0]      fault_code,
    input  logic            take_exc,
    input  logic            ret_exc,
    input  logic [PC_W-1:0] handler_base,
    input  logic [PC_W-1:0] epc_in,
    output logic [PC_W-1:0] pc_out,
    output logic [PC_W-1:0] npc_out,
    output logic [PC_W-1:0] epc_out,
    output logic            epc_we,
    output logic            shadow_enter,
    output logic            shadow_leave,
    output logic            illegal_fault,
    output logic            recheck_irq,
    output logic            unsupported,
    output logic            redirect
);
    localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [PC_W-1:0] npc;
        logic [PC_W-1:0] epc;
        logic            epc_we;
        logic            enter;
        logic            leave;
        logic            illegal;
        logic            recheck;
        logic            unsup;
        logic            redirect;
    } state_t;

    state_t st_d, st_q;

    logic [PC_W-1:0] vec_tgt_w;
    logic            vec_hit_w;
    logic            save_en_w;
    logic [PC_W-1:0] save_val_w;
    logic            ret_ill_w;
    logic [PC_W-1:0] ret_tgt_w;
    logic            ret_leave_w;

    trv_vector_lookup #(.PC_W(PC_W)) u_vec (
        .code   (fault_code),
        .base   (handler_base),
        .target (vec_tgt_w),
        .hit    (vec_hit_w)
    );

    trv_epc_calc #(.PC_W(PC_W)) u_epc (
        .code     (fault_code),
        .cur_pc   (cur_pc),
        .save_en  (save_en_w),
        .save_val (save_val_w)
    );

    trv_return_ctl #(.PC_W(PC_W)) u_ret (
        .cur_pc  (cur_pc),
        .epc_in  (epc_in),
        .base    (handler_base),
        .illegal (ret_ill_w),
        .target  (ret_tgt_w),
        .leave   (ret_leave_w)
    );

    always_comb begin
        st_d          = st_q;
        st_d.epc_we   = 1'b0;
        st_d.enter    = 1'b0;
        st_d.leave    = 1'b0;
        st_d.illegal  = 1'b0;
        st_d.recheck  = 1'b0;
        st_d.unsup    = 1'b0;
        st_d.redirect = 1'b0;
        if (!rst_n) begin
            st_d.pc  = handler_base + PC_W'(OFF_RESET);
            st_d.npc = handler_base + PC_W'(OFF_RESET) + STEP_V;
            st_d.epc = '0;
        end else if (take_exc) begin
            if (vec_hit_w) begin
                st_d.pc       = vec_tgt_w;
                st_d.npc      = vec_tgt_w + STEP_V;
                st_d.redirect = 1'b1;
                st_d.enter    = !cur_pc[0];
                st_d.epc_we   = save_en_w;
                if (save_en_w) st_d.epc = save_val_w;
            end else begin
                st_d.unsup = 1'b1;
            end
        end else if (ret_exc) begin
            st_d.pc       = ret_tgt_w;
            st_d.npc      = ret_tgt_w + STEP_V;
            st_d.redirect = 1'b1;
            if (ret_ill_w) begin
                st_d.illegal = 1'b1;
                st_d.enter   = 1'b1;
                st_d.epc_we  = 1'b1;
                st_d.epc     = cur_pc;
            end else begin
                st_d.leave   = ret_leave_w;
                st_d.recheck = ret_leave_w;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pc_out        = st_q.pc;
    assign npc_out       = st_q.npc;
    assign epc_out       = st_q.epc;
    assign epc_we        = st_q.epc_we;
    assign shadow_enter  = st_q.enter;
    assign shadow_leave  = st_q.leave;
    assign illegal_fault = st_q.illegal;
    assign recheck_irq   = st_q.recheck;
    assign unsupported   = st_q.unsup;
    assign redirect      = st_q.redirect;

    p_shadow_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(shadow_enter && shadow_leave));

    p_intr_priv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_exc && fault_code == EV_INTR && cur_pc[0]) |=> !epc_we);

    p_user_ret_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_exc && ret_exc && !cur_pc[0]) |=> (illegal_fault && shadow_enter));

    p_ret_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_exc && ret_exc && cur_pc[0]) |=> (pc_out == $past(epc_in) && !shadow_enter));

    p_call_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_exc && fault_code == EV_CALL) |=> (epc_out == $past(cur_pc) + STEP_V));

    p_unsup_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (take_exc && fault_code == EV_ARITH) |=> (unsupported && $stable(pc_out) && !epc_we));

endmodule

// File: tb/test_trap_return_unit.sv
module test_trap_return_unit;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] cur_pc, handler_base, epc_in;
    logic [4:0]   fault_code;
    logic         take_exc, ret_exc;
    logic [W-1:0] pc_out, npc_out, epc_out;
    logic         epc_we, shadow_enter, shadow_leave, illegal_fault;
    logic         recheck_irq, unsupported, redirect;

    always #5 clk = ~clk;

    trap_return_unit #(.PC_W(W)) i_trap_return_unit (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .fault_code(fault_code),
        .take_exc(take_exc), .ret_exc(ret_exc), .handler_base(handler_base),
        .epc_in(epc_in), .pc_out(pc_out), .npc_out(npc_out), .epc_out(epc_out),
        .epc_we(epc_we), .shadow_enter(shadow_enter), .shadow_leave(shadow_leave),
        .illegal_fault(illegal_fault), .recheck_irq(recheck_irq),
        .unsupported(unsupported), .redirect(redirect)
    );

    typedef struct {
        string        req;
        logic [W-1:0] pc, npc, epc;
        logic         we, enter, leave, ill, rck, uns, rdr;
    } exp_t;

    exp_t         sb[$];
    int           checks = 0;
    int           errors = 0;
    logic [W-1:0] m_pc, m_npc;
    bit           done = 0;

    task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [14:0] spec_off(logic [4:0] c);
        case (c)
            5'd1:  return {1'b1, 14'h0001};
            5'd2:  return {1'b1, 14'h0401};
            5'd4:  return {1'b1, 14'h0101};
            5'd5:  return {1'b1, 14'h0201};
            5'd6:  return {1'b1, 14'h0281};
            5'd7:  return {1'b1, 14'h0301};
            5'd8, 5'd9:   return {1'b1, 14'h0381};
            5'd10, 5'd11: return {1'b1, 14'h0181};
            5'd12: return {1'b1, 14'h0081};
            5'd13: return {1'b1, 14'h0481};
            5'd14: return {1'b1, 14'h0581};
            5'd15: return {1'b1, 14'h2001};
            5'd16: return {1'b1, 14'h0501};
            default: return '0;
        endcase
    endfunction

    // driver: apply one cycle of stimulus and push the expected result
    task automatic step(string req, logic tk, logic rt, logic [4:0] code,
                        logic [W-1:0] cur, logic [W-1:0] ein);
        exp_t        e;
        logic [14:0] o;
        @(negedge clk);
        take_exc = tk; ret_exc = rt; fault_code = code; cur_pc = cur; epc_in = ein;
        e.req = req; e.pc = m_pc; e.npc = m_npc; e.epc = '0;
        e.we = 0; e.enter = 0; e.leave = 0; e.ill = 0; e.rck = 0; e.uns = 0; e.rdr = 0;
        if (tk) begin
            o = spec_off(code);
            if (o[14]) begin
                e.pc = handler_base + W'(o[13:0]); e.npc = e.pc + 4; e.rdr = 1;
                e.enter = !cur[0];
                if (!(code == 5'd4 && cur[0])) begin
                    e.we = 1; e.epc = (code == 5'd15) ? cur + 4 : cur;
                end
            end else e.uns = 1;
        end else if (rt) begin
            e.rdr = 1;
            if (!cur[0]) begin
                e.ill = 1; e.enter = 1; e.we = 1; e.epc = cur;
                e.pc = handler_base + 32'h481; e.npc = e.pc + 4;
            end else begin
                e.pc = ein; e.npc = ein + 4;
                e.leave = !ein[0]; e.rck = !ein[0];
            end
        end
        m_pc = e.pc; m_npc = e.npc;
        sb.push_back(e);
    endtask

    // monitor: compare just after the edge that registers each pushed item
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(e.req, "pc_out", pc_out, e.pc);
                chk(e.req, "npc_out", npc_out, e.npc);
                chk(e.req, "redirect", W'(redirect), W'(e.rdr));
                chk(e.req, "epc_we", W'(epc_we), W'(e.we));
                if (e.we) chk(e.req, "epc_out", epc_out, e.epc);
                chk(e.req, "shadow_enter", W'(shadow_enter), W'(e.enter));
                chk(e.req, "shadow_leave", W'(shadow_leave), W'(e.leave));
                chk(e.req, "illegal_fault", W'(illegal_fault), W'(e.ill));
                chk(e.req, "recheck_irq", W'(recheck_irq), W'(e.rck));
                chk(e.req, "unsupported", W'(unsupported), W'(e.uns));
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; take_exc = 0; ret_exc = 0; fault_code = '0;
        cur_pc = '0; epc_in = '0; handler_base = 32'h0001_0000;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "pc_out", pc_out, 32'h0001_0001);
        chk("R1", "npc_out", npc_out, 32'h0001_0005);
        chk("R1", "pulses", W'({epc_we, shadow_enter, shadow_leave, illegal_fault,
                                 recheck_irq, unsupported, redirect}), '0);
        m_pc = 32'h0001_0001; m_npc = 32'h0001_0005;
        rst_n = 1;
        // R13: idle hold
        step("R13", 0, 0, 5'd0, 32'h100, 32'h0);
        step("R13", 0, 0, 5'd7, 32'h104, 32'h0);
        // R2 R3 R4 R7: every code from normal mode
        for (int c = 1; c <= 16; c++) begin
            if (c == 3) step("R11", 1, 0, 5'(c), 32'h4000 + 32'(c*8), 32'h0);
            else step("R2", 1, 0, 5'(c), 32'h4000 + 32'(c*8), 32'h0);
        end
        step("R3", 1, 0, 5'd5, 32'h0000_8000, 32'h0);
        step("R4", 1, 0, 5'd7, 32'h0000_8120, 32'h0);
        // R5: interrupt while privileged; R7 no shadow enter
        step("R5", 1, 0, 5'd4, 32'h0001_0105, 32'h0);
        step("R7", 1, 0, 5'd2, 32'h0001_0209, 32'h0);
        // R6: handler call from both modes
        step("R6", 1, 0, 5'd15, 32'h0000_2220, 32'h0);
        step("R6", 1, 0, 5'd15, 32'h0001_2001, 32'h0);
        // R8: return outside privileged mode
        step("R8", 0, 1, 5'd0, 32'h0000_3000, 32'h0000_5000);
        // R9 R10: privileged returns
        step("R9", 0, 1, 5'd0, 32'h0001_0481, 32'h0000_6000);
        step("R10", 0, 1, 5'd0, 32'h0001_0481, 32'h0001_7001);
        // R11: unsupported codes
        step("R11", 1, 0, 5'd0, 32'h0000_1000, 32'h0);
        step("R11", 1, 0, 5'd20, 32'h0000_1004, 32'h0);
        step("R11", 1, 0, 5'd3, 32'h0001_1001, 32'h0);
        // R12: both strobes
        step("R12", 1, 1, 5'd10, 32'h0001_0101, 32'h0000_9000);
        step("R12", 1, 1, 5'd3, 32'h0001_0101, 32'h0000_9000);
        // R3: base change
        @(negedge clk); handler_base = 32'h00A0_0000;
        step("R3", 1, 0, 5'd14, 32'h0000_0040, 32'h0);
        step("R13", 0, 0, 5'd0, 32'h0, 32'h0);
        step("R13", 0, 0, 5'd0, 32'h0, 32'h0);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule